// File: doc/BRIEF.md
# Multithreaded Register Frame Controller

This block sits beside the issue stage of a block-multithreaded core. Its register file is divided into four context frames, each a full register set for one thread. A frame pointer names the running context, and register reads and writes from the pipeline are addressed within that frame only. The pipeline asks for a context switch when the running thread takes a cache miss or a synchronization fault. The controller then records that thread's resume PC and marks its frame as waiting. It moves the frame pointer round-robin to the next frame that is resident and ready, and hands the pipeline that frame's saved PC. No register contents are copied.

While the switch is in progress, issue is stalled for a fixed number of cycles. If no resident frame is ready, the controller raises a trap so that a software loader can unload a frame and install another thread. It holds the trap until an install or a miss completion makes a frame ready, and then finishes the switch. Miss completions mark their frame ready again.

Top module: `ctx_frame_ctrl`

## Requirements
- R1: After reset the frame pointer is 0, `pc` is 0, `stall`, `trap` and `pc_load` are low, every register reads 0, frame 0 is resident and ready, and frames 1 to 3 are not resident.
- R2: Register accesses use address {frame pointer, register index}. A write made while one frame is active is never visible through another frame, and each frame's values are still present when that frame becomes active again.
- R3: An accepted `ev_valid` (one sampled while `stall` is low) makes `stall` high for exactly SWITCH_CYCLES (2) cycles. When a ready frame exists, `pc_load` pulses high for one cycle in the cycle after those two, with `stall` low.
- R4: The new frame is the first frame that is resident and ready, searching in the order fp+1, fp+2, fp+3 modulo 4. Frames that are waiting or not resident are skipped.
- R5: `ev_pc` is saved as the leaving frame's resume PC. On `pc_load`, `pc` equals the saved or installed PC of the new frame.
- R6: `done_valid` with `done_frame` marks that resident frame ready again.
- R7: If at the end of the switch no frame is resident and ready, `trap` and `stall` go high and stay high. One cycle after a frame becomes ready, `trap` falls. `stall` then stays high for a further SWITCH_CYCLES cycles, after which the switch completes as in R3 to R5.
- R8: `wr_en` has no effect while `stall` is high.
- R9: With no event, the frame pointer does not change, so a thread runs for as long as it does not miss or fault.
- R10: `inst_valid` with `inst_frame` and `inst_pc` makes that frame resident and ready, with `inst_pc` as its resume PC.
- R11: If the leaving frame itself becomes ready during the switch and no other frame is ready, it is selected again, and `pc` is the PC it just saved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Switch event (miss or sync fault) for the running thread |
| ev_pc | input | 12 | Resume PC of the running thread |
| done_valid | input | 1 | Outstanding miss of a frame completed |
| done_frame | input | 2 | Frame whose miss completed |
| inst_valid | input | 1 | Software loader installs a thread |
| inst_frame | input | 2 | Frame being installed |
| inst_pc | input | 12 | Start PC of the installed thread |
| rd_idx | input | 3 | Read register index within the active frame |
| rd_data | output | 16 | Read data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 3 | Write register index within the active frame |
| wr_data | input | 16 | Write data |
| fp | output | 2 | Active frame pointer |
| pc | output | 12 | PC to fetch from after a switch |
| pc_load | output | 1 | One-cycle pulse: fetch restarts from `pc` |
| stall | output | 1 | Issue stalled (switch or trap pending) |
| trap | output | 1 | Request for the software loader |

## Verification
The round-robin choice is driven through three kinds of ready-set pattern. Only a later frame ready shows that waiting frames are skipped. Only an earlier frame ready shows wrap-around. A long sweep of events, interleaved with miss completions to frames chosen arithmetically, distinguishes the search order from a fixed-priority pick. Cases with no frame ready and with only the leaving frame ready separate the trap path from self-reselection. Register patterns that encode frame and index, written in every frame and read back after later switches, expose any address overlap, and a write attempted during the stall shows whether the write enable is gated.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SWITCH = 2'd1,
    ST_TRAP   = 2'd2
  } ctx_state_e;
endpackage

// File: rtl/ctx_regfile.sv
module ctx_regfile #(
  parameter int N_FRAMES = 4,
  parameter int N_REGS   = 8,
  parameter int DATA_W   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(N_FRAMES)-1:0] fp_i,
  input  logic                        stall_i,
  input  logic [$clog2(N_REGS)-1:0]   rd_idx_i,
  output logic [DATA_W-1:0]           rd_data_o,
  input  logic                        wr_en_i,
  input  logic [$clog2(N_REGS)-1:0]   wr_idx_i,
  input  logic [DATA_W-1:0]           wr_data_i
);
  localparam int FP_W  = $clog2(N_FRAMES);
  localparam int IDX_W = $clog2(N_REGS);
  localparam int DEPTH = N_FRAMES * N_REGS;

  logic [DEPTH-1:0][DATA_W-1:0] mem_q, mem_d;
  logic [FP_W+IDX_W-1:0]        wr_addr, rd_addr;
  logic                         wr_ce;

  assign wr_addr = {fp_i, wr_idx_i};
  assign rd_addr = {fp_i, rd_idx_i};
  assign wr_ce   = wr_en_i && !stall_i;

  always_comb begin
    mem_d = mem_q;
    if (wr_ce) mem_d[wr_addr] = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else if (wr_ce) mem_q <= mem_d;
  end

  assign rd_data_o = mem_q[rd_addr];

  AST_NO_WR_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> (mem_q == $past(mem_q))); // R8
endmodule

// File: rtl/ctx_pick.sv
module ctx_pick #(
  parameter int N_FRAMES = 4
) (
  input  logic [$clog2(N_FRAMES)-1:0] fp_i,
  input  logic [N_FRAMES-1:0]         avail_i,
  output logic                        found_o,
  output logic [$clog2(N_FRAMES)-1:0] next_o
);
  localparam int FP_W = $clog2(N_FRAMES);

  // Scan from the farthest offset to the nearest so the nearest hit wins;
  // offset N_FRAMES wraps to the current frame itself.
  always_comb begin
    logic [FP_W-1:0] cand;
    found_o = 1'b0;
    next_o  = fp_i;
    cand    = fp_i;
    for (int i = N_FRAMES; i >= 1; i--) begin
      cand = fp_i + FP_W'(i);
      if (avail_i[cand]) begin
        found_o = 1'b1;
        next_o  = cand;
      end
    end
  end
endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
  import ctx_pkg::*;
#(
  parameter int N_FRAMES = 4,
  parameter int PC_W     = 12,
  parameter int SW_CYC   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ev_valid_i,
  input  logic [PC_W-1:0]             ev_pc_i,
  input  logic                        done_valid_i,
  input  logic [$clog2(N_FRAMES)-1:0] done_frame_i,
  input  logic                        inst_valid_i,
  input  logic [$clog2(N_FRAMES)-1:0] inst_frame_i,
  input  logic [PC_W-1:0]             inst_pc_i,
  input  logic                        pick_found_i,
  input  logic [$clog2(N_FRAMES)-1:0] pick_frame_i,
  output logic [N_FRAMES-1:0]         avail_o,
  output logic [$clog2(N_FRAMES)-1:0] fp_o,
  output logic [PC_W-1:0]             pc_o,
  output logic                        pc_load_o,
  output logic                        stall_o,
  output logic                        trap_o
);
  localparam int FP_W  = $clog2(N_FRAMES);
  localparam int CNT_W = $clog2(SW_CYC + 1);

  ctx_state_e                 st_q, st_d;
  logic [CNT_W-1:0]           cnt_q, cnt_d;
  logic [FP_W-1:0]            fp_q, fp_d;
  logic [N_FRAMES-1:0]        valid_q, valid_d, ready_q, ready_d;
  logic [N_FRAMES-1:0][PC_W-1:0] pcm_q, pcm_d;
  logic [PC_W-1:0]            pc_q, pc_d;
  logic                       load_q, load_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    fp_d    = fp_q;
    valid_d = valid_q;
    ready_d = ready_q;
    pcm_d   = pcm_q;
    pc_d    = pc_q;
    load_d  = 1'b0;
    if (done_valid_i && valid_q[done_frame_i]) ready_d[done_frame_i] = 1'b1;
    if (inst_valid_i) begin
      valid_d[inst_frame_i] = 1'b1;
      ready_d[inst_frame_i] = 1'b1;
      pcm_d[inst_frame_i]   = inst_pc_i;
    end
    unique case (st_q)
      ST_RUN: begin
        if (ev_valid_i) begin
          ready_d[fp_q] = 1'b0;
          pcm_d[fp_q]   = ev_pc_i;
          st_d          = ST_SWITCH;
          cnt_d         = CNT_W'(SW_CYC - 1);
        end
      end
      ST_SWITCH: begin
        if (cnt_q == '0) begin
          if (pick_found_i) begin
            fp_d   = pick_frame_i;
            pc_d   = pcm_q[pick_frame_i];
            load_d = 1'b1;
            st_d   = ST_RUN;
          end else begin
            st_d = ST_TRAP;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_TRAP: begin
        if (|avail_o) begin
          st_d  = ST_SWITCH;
          cnt_d = CNT_W'(SW_CYC - 1);
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      cnt_q   <= '0;
      fp_q    <= '0;
      valid_q <= {{(N_FRAMES-1){1'b0}}, 1'b1};
      ready_q <= {{(N_FRAMES-1){1'b0}}, 1'b1};
      pcm_q   <= '0;
      pc_q    <= '0;
      load_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      fp_q    <= fp_d;
      valid_q <= valid_d;
      ready_q <= ready_d;
      pcm_q   <= pcm_d;
      pc_q    <= pc_d;
      load_q  <= load_d;
    end
  end

  assign avail_o   = valid_q & ready_q;
  assign fp_o      = fp_q;
  assign pc_o      = pc_q;
  assign pc_load_o = load_q;
  assign stall_o   = (st_q != ST_RUN);
  assign trap_o    = (st_q == ST_TRAP);

  AST_FP_HOLD_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |=> (fp_q == $past(fp_q))); // R9
  AST_EVENT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_i && !stall_o) |=> stall_o); // R3
  AST_LOAD_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |-> ($past(stall_o) && !stall_o)); // R3
  AST_PICK_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |-> avail_o[fp_q]); // R4
  AST_TRAP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_o) |-> ($past(avail_o) == '0)); // R7
endmodule

// File: rtl/ctx_frame_ctrl.sv
module ctx_frame_ctrl #(
  parameter int N_FRAMES = 4,
  parameter int N_REGS   = 8,
  parameter int DATA_W   = 16,
  parameter int PC_W     = 12,
  parameter int SW_CYC   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ev_valid,
  input  logic [PC_W-1:0]             ev_pc,
  input  logic                        done_valid,
  input  logic [$clog2(N_FRAMES)-1:0] done_frame,
  input  logic                        inst_valid,
  input  logic [$clog2(N_FRAMES)-1:0] inst_frame,
  input  logic [PC_W-1:0]             inst_pc,
  input  logic [$clog2(N_REGS)-1:0]   rd_idx,
  output logic [DATA_W-1:0]           rd_data,
  input  logic                        wr_en,
  input  logic [$clog2(N_REGS)-1:0]   wr_idx,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [$clog2(N_FRAMES)-1:0] fp,
  output logic [PC_W-1:0]             pc,
  output logic                        pc_load,
  output logic                        stall,
  output logic                        trap
);
  localparam int FP_W = $clog2(N_FRAMES);

  logic [N_FRAMES-1:0] avail;
  logic                pick_found;
  logic [FP_W-1:0]     pick_frame;

  ctx_pick #(.N_FRAMES(N_FRAMES)) u_pick (
    .fp_i    (fp),
    .avail_i (avail),
    .found_o (pick_found),
    .next_o  (pick_frame)
  );

  ctx_seq #(.N_FRAMES(N_FRAMES), .PC_W(PC_W), .SW_CYC(SW_CYC)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_valid_i   (ev_valid),
    .ev_pc_i      (ev_pc),
    .done_valid_i (done_valid),
    .done_frame_i (done_frame),
    .inst_valid_i (inst_valid),
    .inst_frame_i (inst_frame),
    .inst_pc_i    (inst_pc),
    .pick_found_i (pick_found),
    .pick_frame_i (pick_frame),
    .avail_o      (avail),
    .fp_o         (fp),
    .pc_o         (pc),
    .pc_load_o    (pc_load),
    .stall_o      (stall),
    .trap_o       (trap)
  );

  ctx_regfile #(.N_FRAMES(N_FRAMES), .N_REGS(N_REGS), .DATA_W(DATA_W)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .fp_i      (fp),
    .stall_i   (stall),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data)
  );
endmodule

// File: tb/test_ctx_frame_ctrl.sv
`timescale 1ns/1ps
module test_ctx_frame_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_valid, done_valid, inst_valid, wr_en;
  logic [11:0] ev_pc, inst_pc;
  logic [1:0]  done_frame, inst_frame;
  logic [2:0]  rd_idx, wr_idx;
  logic [15:0] rd_data, wr_data;
  logic [1:0]  fp;
  logic [11:0] pc;
  logic        pc_load, stall, trap;

  int n_chk = 0;
  int n_fail = 0;

  // model
  bit          m_valid [4];
  bit          m_ready [4];
  logic [11:0] m_pc [4];
  int          m_fp;
  bit          in_trap;

  always #2.5 clk = ~clk;

  ctx_frame_ctrl i_ctx_frame_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_pc(ev_pc),
    .done_valid(done_valid), .done_frame(done_frame),
    .inst_valid(inst_valid), .inst_frame(inst_frame), .inst_pc(inst_pc),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .fp(fp), .pc(pc), .pc_load(pc_load), .stall(stall), .trap(trap)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int f, input int i);
    return 16'h5000 + 16'(f * 256) + 16'(i * 17);
  endfunction

  task automatic wr_frame(input int f);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); wr_en = 1'b1; wr_idx = 3'(i); wr_data = pat(f, i);
    end
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_frame(input string req, input int f);
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i); #0.5;
      chk(req, rd_data, pat(f, i));
    end
  endtask

  // called at the negedge right after the resolving edge
  task automatic resolve();
    int pick = -1;
    for (int k = 4; k >= 1; k--) begin
      int c = (m_fp + k) % 4;
      if (m_valid[c] && m_ready[c]) pick = c;
    end
    if (pick >= 0) begin
      chk("R3 stall low after switch", stall, 0);
      chk("R3 pc_load pulse", pc_load, 1);
      chk("R4 round-robin frame", fp, pick);
      chk("R5 restored pc", pc, m_pc[pick]);
      m_fp = pick; in_trap = 0;
      @(negedge clk);
      chk("R3 pc_load one cycle", pc_load, 0);
    end else begin
      chk("R7 trap raised", trap, 1);
      chk("R7 stall during trap", stall, 1);
      in_trap = 1;
    end
  endtask

  task automatic do_ev(input logic [11:0] p, input bit wr_in_stall, input bit self_done);
    @(negedge clk);
    chk("R3 no stall before event", stall, 0);
    ev_valid = 1'b1; ev_pc = p;
    @(negedge clk);
    ev_valid = 1'b0;
    m_ready[m_fp] = 0; m_pc[m_fp] = p;
    chk("R3 stall cycle 1", stall, 1);
    chk("R3 no pc_load in stall", pc_load, 0);
    if (wr_in_stall) begin wr_en = 1'b1; wr_idx = 3'd0; wr_data = 16'hDEAD; end
    if (self_done) begin done_valid = 1'b1; done_frame = 2'(m_fp); end
    @(negedge clk);
    wr_en = 1'b0;
    if (self_done) begin done_valid = 1'b0; m_ready[m_fp] = 1; end
    chk("R3 stall cycle 2", stall, 1);
    @(negedge clk);
    resolve();
  endtask

  task automatic recover_wait();
    chk("R7 trap held one cycle", trap, 1);
    @(negedge clk);
    chk("R7 trap released", trap, 0);
    chk("R7 stall after trap 1", stall, 1);
    @(negedge clk);
    chk("R7 stall after trap 2", stall, 1);
    @(negedge clk);
    resolve();
  endtask

  task automatic do_done(input int f);
    @(negedge clk); done_valid = 1'b1; done_frame = 2'(f);
    @(negedge clk); done_valid = 1'b0;
    if (m_valid[f]) m_ready[f] = 1;
    if (in_trap && m_valid[f]) recover_wait();
  endtask

  task automatic do_inst(input int f, input logic [11:0] p);
    @(negedge clk); inst_valid = 1'b1; inst_frame = 2'(f); inst_pc = p;
    @(negedge clk); inst_valid = 1'b0;
    m_valid[f] = 1; m_ready[f] = 1; m_pc[f] = p;
    if (in_trap) recover_wait();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ev_valid = 0; done_valid = 0; inst_valid = 0; wr_en = 0;
    ev_pc = '0; inst_pc = '0; done_frame = '0; inst_frame = '0;
    rd_idx = '0; wr_idx = '0; wr_data = '0;
    for (int f = 0; f < 4; f++) begin m_valid[f] = (f == 0); m_ready[f] = (f == 0); m_pc[f] = '0; end
    m_fp = 0; in_trap = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fp", fp, 0);
    chk("R1 pc", pc, 0);
    chk("R1 stall", stall, 0);
    chk("R1 trap", trap, 0);
    chk("R1 pc_load", pc_load, 0);
    rd_idx = 3'd5; #0.5; chk("R1 reg zero", rd_data, 0);

    wr_frame(0);
    rd_frame("R2 frame0 write", 0);
    // R10 installs; R9 no switch while running
    do_inst(1, 12'h101); do_inst(2, 12'h102); do_inst(3, 12'h103);
    repeat (5) @(negedge clk);
    chk("R9 fp held without event", fp, 0);
    chk("R9 no stall without event", stall, 0);

    do_ev(12'h0A0, 0, 0);                     // -> 1, pc 101 (R10)
    rd_idx = 3'd0; #0.5; chk("R2 frame1 isolated from frame0", rd_data, 0);
    wr_frame(1);
    do_ev(12'h0B1, 0, 0);                     // -> 2
    wr_frame(2);
    do_done(0);                               // R6
    do_ev(12'h0C2, 0, 0);                     // -> 3, skips nothing before 3
    wr_frame(3);
    do_ev(12'h0D3, 0, 0);                     // wrap to 0, pc 0A0 (R4, R5)
    rd_frame("R2 frame0 kept", 0);
    // R8: write during stall then trap
    do_ev(12'h0E0, 1, 0);                     // all waiting -> trap (R7)
    repeat (4) begin
      @(negedge clk);
      chk("R7 trap held", trap, 1);
    end
    do_done(2);                               // recover to 2
    rd_frame("R2 frame2 kept", 2);
    // R11 self reselect
    do_ev(12'h0F2, 0, 1);
    chk("R11 same frame reselected", fp, 2);
    chk("R11 pc is just-saved pc", pc, 12'h0F2);
    do_inst(1, 12'h155);                      // R10 reload
    do_ev(12'h0F3, 0, 0);                     // from 2: 3 wait,0 wait,1 ready -> 1
    chk("R10 installed pc used", pc, 12'h155);
    do_done(0);
    do_ev(12'h011, 0, 0);                     // -> 0
    rd_idx = 3'd0; #0.5; chk("R8 write during stall ignored", rd_data, pat(0, 0));

    // sweep of events and completions
    for (int it = 0; it < 60; it++) begin
      if (it % 3 != 0) do_done((it * 3 + 1) % 4);
      if (it % 5 == 0) do_done((it + 2) % 4);
      do_ev(12'(12'h200 + it), 0, (it % 11 == 7));
      if (in_trap) do_done((it + 1) % 4);
    end
    for (int f = 0; f < 4; f++) m_ready[f] = m_ready[f];
    rd_frame("R2 final frame contents", m_fp == 1 ? 1 : m_fp);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule